// File: doc/BRIEF.md
# Task-Side Endpoint Word Sequencer

This block sits between a hardware task's logic and the 32-bit endpoint of its reconfigurable slice. The slice has one 32-bit output word lane and one 32-bit input word lane. Every command, address and data word uses these two lanes. When the task asks for a memory access, the sequencer sends a command word first. It then sends the rest of the access one word per accepted transfer, in a fixed order. Valid/ready handshakes govern the task-side request, the endpoint lanes and the task's stream ports.

Two kinds of access are built. The first is a single full-word memory write, sent as three words: command, address, data. The second is a streamed block transfer, read or write. It sends a command that carries a 22-bit word count, then the start address. After that, one data word moves on every clock where both sides are ready. During a block write, data passes from the task's write-stream port to the endpoint output. During a block read, data passes from the endpoint input to the task's read-stream port. A one-cycle `done` pulse marks the end of each request.

Top module: `task_endpoint_seq`

## Requirements
- R1: While reset is held, `ep_out_valid`, `done`, `wr_ready`, `rd_valid` and `ep_in_ready` are 0 and `req_ready` is 1.
- R2: A request of kind 0 (single write) produces exactly three output words: the command (bits [31:27] = 01011, bits [26:0] = 0), then `req_addr`, then `req_data`. The first word of every access carries destination class 01 (memory) in bits [31:30].
- R3: While `ep_out_valid` is 1 and `ep_out_ready` is 0, the next cycle keeps `ep_out_valid` at 1 with `ep_out_data` unchanged (stream source assumed to hold its word as well).
- R4: A request of kind 1 (block read) sends a command word with bits [31:30] = 01, bit 29 = 1, bits [28:22] = 0000010 and bits [21:0] = length. The start address follows.
- R5: A request of kind 2 (block write) sends a command word with bits [31:30] = 01, bit 29 = 1, bits [28:22] = 1000010 and bits [21:0] = length. The start address follows.
- R6: During a block write, exactly `length` words pass from `wr_data` to `ep_out_data` in order. `ep_out_valid` follows `wr_valid`, and `wr_ready` follows `ep_out_ready`.
- R7: During a block read, exactly `length` words pass from `ep_in_data` to `rd_data` in order. `ep_in_ready` follows `rd_ready`, and it is 0 at all other times.
- R8: `done` is 1 for one cycle in the cycle after the handshake of the last word of an access.
- R9: A block request with length 0 sends no word and raises `done` in the cycle after acceptance.
- R10: `req_ready` is 0 from the cycle after a request is accepted until `done` rises.
- R11: With the endpoint and the stream always ready, the first block data word is transferred in the third cycle after acceptance. This is two setup cycles, for the command and the address.
- R12: A request of kind 3 (reserved) sends no word and raises `done` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Task request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_kind | input | 2 | 0 single write, 1 block read, 2 block write, 3 reserved |
| req_addr | input | 32 | Write address or block start address |
| req_data | input | 32 | Data for a single write |
| req_len | input | LEN_W | Block length in words |
| done | output | 1 | Access finished pulse |
| wr_data | input | 32 | Block write stream word from task |
| wr_valid | input | 1 | Block write stream word present |
| wr_ready | output | 1 | Block write stream word taken |
| rd_data | output | 32 | Block read stream word to task |
| rd_valid | output | 1 | Block read stream word present |
| rd_ready | input | 1 | Task takes read stream word |
| ep_out_data | output | 32 | Endpoint output word lane |
| ep_out_valid | output | 1 | Output word present |
| ep_out_ready | input | 1 | Endpoint takes output word |
| ep_in_data | input | 32 | Endpoint input word lane |
| ep_in_valid | input | 1 | Input word present |
| ep_in_ready | output | 1 | Sequencer takes input word |

## Verification
The bench builds the block with LEN_W = 22, the full length field, so the command-word layout is checked bit for bit, including the length bits. Block lengths stay between 0 and 12. This makes zero-length requests, one-word blocks and counter reloads across back-to-back requests frequent, while every run stays short. Random ready and valid rates from 30 to 100 percent stall every word position, and one directed run at full rates pins the two-cycle setup cost.

// File: rtl/tep_pkg.sv
// Shared types and command-word constants for the task endpoint sequencer.
// Assumes a 32-bit endpoint word and a 22-bit block length field.
package tep_pkg;
    localparam int WORD_W      = 32;
    localparam int LEN_FIELD_W = 22;

    // Request kinds offered to the task logic
    typedef enum logic [1:0] {
        KIND_WR1 = 2'b00,
        KIND_BRD = 2'b01,
        KIND_BWR = 2'b10,
        KIND_RSV = 2'b11
    } acc_kind_t;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_SDATA,
        ST_STREAM
    } seq_state_t;

    // Destination classes in bits [31:30] of a command word
    localparam logic [1:0] DEST_SYS  = 2'b00;
    localparam logic [1:0] DEST_MEM  = 2'b01;
    localparam logic [1:0] DEST_TASK = 2'b10;
    localparam logic [1:0] DEST_IO   = 2'b11;

    // Bits [29:27] of a single full-word write command
    localparam logic [2:0] OP_SINGLE_WR = 3'b011;
    // Bits [28:22] of block transfer commands
    localparam logic [6:0] OP_BLK_RD = 7'b0000010;
    localparam logic [6:0] OP_BLK_WR = 7'b1000010;

    // Destination class of a command word
    function automatic logic [1:0] dest_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: 2];
    endfunction
endpackage

// File: rtl/tep_cmd_former.sv
// Forms the command word for a request.
// Assumes LEN_W <= 22; shorter lengths are zero-extended into the length field.
module tep_cmd_former
    import tep_pkg::*;
#(
    parameter int LEN_W = 22
) (
    input  acc_kind_t          kind,
    input  logic [LEN_W-1:0]   len,
    output logic [WORD_W-1:0]  cmd
);
    logic [LEN_FIELD_W-1:0] len_field;

    // Fit the request length into the command's length field
    generate
        if (LEN_W < LEN_FIELD_W) begin : g_pad
            assign len_field = {{(LEN_FIELD_W-LEN_W){1'b0}}, len};
        end else begin : g_full
            assign len_field = len[LEN_FIELD_W-1:0];
        end
    endgenerate

    // Assemble the word by request kind
    always_comb begin
        case (kind)
            KIND_WR1: cmd = {DEST_MEM, OP_SINGLE_WR, 27'd0};
            KIND_BRD: cmd = {DEST_MEM, 1'b1, OP_BLK_RD, len_field};
            KIND_BWR: cmd = {DEST_MEM, 1'b1, OP_BLK_WR, len_field};
            default:  cmd = '0;
        endcase
    end
endmodule

// File: rtl/tep_beat_counter.sv
// Counts the remaining stream words of a block transfer.
// Assumes load and dec are never both asserted in the same cycle.
module tep_beat_counter #(
    parameter int LEN_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [LEN_W-1:0] cnt;

    // Load at request acceptance, count down per stream word
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (dec && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign last = (cnt == LEN_W'(1));
endmodule

// File: rtl/tep_ctrl.sv
// Phase controller: takes requests, steps through command, address and
// data phases, and pulses done. Assumes the word lanes are muxed outside.
module tep_ctrl
    import tep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  acc_kind_t  req_kind,
    input  logic       len_zero,
    input  logic       ep_out_ready,
    input  logic       wr_valid,
    input  logic       ep_in_valid,
    input  logic       rd_ready,
    input  logic       last,
    output seq_state_t state,
    output acc_kind_t  kind_q,
    output logic       accept,
    output logic       beat,
    output logic       done
);
    seq_state_t state_n;
    logic       done_n;
    logic       no_words;

    assign accept   = req_valid && (state == ST_IDLE);
    assign no_words = (req_kind == KIND_RSV) ||
                      ((req_kind == KIND_BRD || req_kind == KIND_BWR) && len_zero);

    // One stream word moves this cycle
    always_comb begin
        beat = 1'b0;
        if (state == ST_STREAM) begin
            if (kind_q == KIND_BWR) beat = wr_valid && ep_out_ready;
            else                    beat = ep_in_valid && rd_ready;
        end
    end

    // Next phase and completion
    always_comb begin
        state_n = state;
        done_n  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (no_words) done_n  = 1'b1;
                    else          state_n = ST_CMD;
                end
            end
            ST_CMD: if (ep_out_ready) state_n = ST_ADDR;
            ST_ADDR: begin
                if (ep_out_ready)
                    state_n = (kind_q == KIND_WR1) ? ST_SDATA : ST_STREAM;
            end
            ST_SDATA: begin
                if (ep_out_ready) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end
            end
            ST_STREAM: begin
                if (beat && last) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Phase, kind and done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= KIND_WR1;
            done   <= 1'b0;
        end else begin
            state <= state_n;
            done  <= done_n;
            if (accept) kind_q <= req_kind;
        end
    end
endmodule

// File: rtl/task_endpoint_seq.sv
// Task-side endpoint sequencer top. Captures a request, then drives the
// command word, address and data words onto the endpoint output lane, or
// bridges a block stream between the task ports and the endpoint lanes.
// Assumes stream sources hold their word while valid and not ready.
module task_endpoint_seq
    import tep_pkg::*;
#(
    parameter int LEN_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_data,
    input  logic [LEN_W-1:0]  req_len,
    output logic              done,
    input  logic [31:0]       wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [31:0]       ep_out_data,
    output logic              ep_out_valid,
    input  logic              ep_out_ready,
    input  logic [31:0]       ep_in_data,
    input  logic              ep_in_valid,
    output logic              ep_in_ready
);
    seq_state_t        state;
    acc_kind_t         kind_q;
    acc_kind_t         kind_in;
    logic              accept;
    logic              beat;
    logic              last;
    logic [WORD_W-1:0] cmd_w;
    logic [WORD_W-1:0] cmd_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;

    assign kind_in = acc_kind_t'(req_kind);

    tep_cmd_former #(.LEN_W(LEN_W)) u_cmd (
        .kind (kind_in),
        .len  (req_len),
        .cmd  (cmd_w)
    );

    tep_beat_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (req_len),
        .dec      (beat),
        .last     (last)
    );

    tep_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_kind     (kind_in),
        .len_zero     (req_len == '0),
        .ep_out_ready (ep_out_ready),
        .wr_valid     (wr_valid),
        .ep_in_valid  (ep_in_valid),
        .rd_ready     (rd_ready),
        .last         (last),
        .state        (state),
        .kind_q       (kind_q),
        .accept       (accept),
        .beat         (beat),
        .done         (done)
    );

    // Capture the command, address and single-write data at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            cmd_q  <= cmd_w;
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    assign req_ready = (state == ST_IDLE);

    // Drive the lanes for the current phase
    always_comb begin
        ep_out_data  = cmd_q;
        ep_out_valid = 1'b0;
        wr_ready     = 1'b0;
        rd_data      = ep_in_data;
        rd_valid     = 1'b0;
        ep_in_ready  = 1'b0;
        case (state)
            ST_CMD: begin
                ep_out_data  = cmd_q;
                ep_out_valid = 1'b1;
            end
            ST_ADDR: begin
                ep_out_data  = addr_q;
                ep_out_valid = 1'b1;
            end
            ST_SDATA: begin
                ep_out_data  = data_q;
                ep_out_valid = 1'b1;
            end
            ST_STREAM: begin
                if (kind_q == KIND_BWR) begin
                    ep_out_data  = wr_data;
                    ep_out_valid = wr_valid;
                    wr_ready     = ep_out_ready;
                end else begin
                    rd_valid     = ep_in_valid;
                    ep_in_ready  = rd_ready;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tep_checker.sv
// Port-level properties of the task endpoint sequencer, bound to the top.
// Assumes stream sources hold their word while valid and not ready.
module tep_checker
    import tep_pkg::*;
#(
    parameter int LEN_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_kind,
    input logic [LEN_W-1:0] req_len,
    input logic             done,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic [31:0]      ep_out_data,
    input logic             ep_out_valid,
    input logic             ep_out_ready,
    input logic             ep_in_ready
);
    logic want_cmd;

    // Tracks that the next output word must be a command
    always_ff @(posedge clk) begin
        if (!rst_n)                            want_cmd <= 1'b0;
        else if (req_valid && req_ready)       want_cmd <= 1'b1;
        else if (ep_out_valid && ep_out_ready) want_cmd <= 1'b0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ep_out_valid && !done && !wr_ready && !rd_valid && !ep_in_ready));

    assert_first_is_mem_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (want_cmd && ep_out_valid) |-> (dest_of(ep_out_data) == DEST_MEM));

    assert_hold_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_out_valid && !ep_out_ready) |=> (ep_out_valid && $stable(ep_out_data)));

    assert_in_ready_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ep_in_ready |-> !req_ready);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_kind == 2'b01 || req_kind == 2'b10) && req_len == '0)
        |=> (done && !ep_out_valid));

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready || done));

    assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'b11) |=> (done && !ep_out_valid));
endmodule

bind task_endpoint_seq tep_checker #(.LEN_W(LEN_W)) u_tep_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_len      (req_len),
    .done         (done),
    .wr_ready     (wr_ready),
    .rd_valid     (rd_valid),
    .ep_out_data  (ep_out_data),
    .ep_out_valid (ep_out_valid),
    .ep_out_ready (ep_out_ready),
    .ep_in_ready  (ep_in_ready)
);

// File: tb/test_task_endpoint_seq.sv
// Bench for task_endpoint_seq: directed corners plus seeded random requests
// with random stalls, checked against bench-computed word sequences.
module test_task_endpoint_seq;
    localparam int LEN_W = 22;

    logic             clk;
    logic             rst_n;
    logic             req_valid;
    logic             req_ready;
    logic [1:0]       req_kind;
    logic [31:0]      req_addr;
    logic [31:0]      req_data;
    logic [LEN_W-1:0] req_len;
    logic             done;
    logic [31:0]      wr_data;
    logic             wr_valid;
    logic             wr_ready;
    logic [31:0]      rd_data;
    logic             rd_valid;
    logic             rd_ready;
    logic [31:0]      ep_out_data;
    logic             ep_out_valid;
    logic             ep_out_ready;
    logic [31:0]      ep_in_data;
    logic             ep_in_valid;
    logic             ep_in_ready;

    int checks = 0;
    int errors = 0;

    task_endpoint_seq #(.LEN_W(LEN_W)) i_task_endpoint_seq (.*);

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Record one check
    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected command word per requirement R2/R4/R5
    function automatic logic [31:0] exp_cmd(input int kind, input int len);
        logic [21:0] l;
        l = 22'(len);
        case (kind)
            0:       return {2'b01, 3'b011, 27'd0};
            1:       return {2'b01, 1'b1, 7'b0000010, l};
            default: return {2'b01, 1'b1, 7'b1000010, l};
        endcase
    endfunction

    function automatic logic [31:0] wpat(input logic [31:0] a, input int k);
        return a ^ (32'(k) * 32'h9E37_79B1);
    endfunction

    function automatic logic [31:0] rpat(input logic [31:0] a, input int k);
        return ~a + (32'(k) * 32'h0101_0307);
    endfunction

    function automatic bit coin(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    // Issue one request and follow it to done
    task automatic run_txn(input int kind, input logic [31:0] addr,
                           input logic [31:0] data, input int len,
                           input int pct, output int first_beat);
        int          n_out, n_rd, idx, rdn, wk, samp;
        bit          pend, hold, busy_ok, exp_done;
        logic [31:0] held, ew;
        string       dtag, ctag;
        n_out = (kind == 0) ? 3 : (kind == 3 || len == 0) ? 0 : (kind == 2 ? 2 + len : 2);
        n_rd  = (kind == 1) ? len : 0;
        ctag  = (kind == 0) ? "R2" : (kind == 1) ? "R4" : "R5";
        dtag  = (kind == 3) ? "R12" : (n_out == 0) ? "R9" : "R8";
        first_beat = -1;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_addr  = addr;
        req_data  = data;
        req_len   = LEN_W'(len);
        #1;
        chk(req_ready == 1'b1, "R10", "idle ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        idx = 0; rdn = 0; wk = 0; samp = 0;
        pend = 1'b0; hold = 1'b0; busy_ok = 1'b1; held = '0;
        exp_done = (n_out == 0 && n_rd == 0);
        forever begin
            req_valid    = 1'b0;
            ep_out_ready = coin(pct);
            ep_in_valid  = coin(pct);
            rd_ready     = coin(pct);
            wr_valid     = pend | coin(pct);
            wr_data      = wpat(addr, wk);
            ep_in_data   = rpat(addr, rdn);
            #1;
            samp++;
            if (hold)
                chk(ep_out_valid && ep_out_data == held, "R3", "held word",
                    ep_out_data, held);
            if (done || exp_done) begin
                chk(done == exp_done, dtag, "done timing", 32'(done), 32'(exp_done));
                break;
            end
            if (req_ready) busy_ok = 1'b0;
            if (ep_out_valid && ep_out_ready) begin
                if (idx == 0) begin
                    ew = exp_cmd(kind, len);
                    chk(ep_out_data == ew, ctag, "command word", ep_out_data, ew);
                end else if (idx == 1) begin
                    chk(ep_out_data == addr, ctag, "address word", ep_out_data, addr);
                end else if (kind == 0) begin
                    chk(ep_out_data == data, "R2", "single data word", ep_out_data, data);
                end else begin
                    ew = wpat(addr, idx - 2);
                    chk(ep_out_data == ew, "R6", "write stream word", ep_out_data, ew);
                end
                if (idx == 2 && first_beat < 0) first_beat = samp;
                idx++;
            end
            if (rd_valid && rd_ready) begin
                ew = rpat(addr, rdn);
                chk(rd_data == ew, "R7", "read stream word", rd_data, ew);
                if (rdn == 0) first_beat = samp;
                rdn++;
            end
            if (wr_valid && wr_ready) wk++;
            pend = wr_valid && !wr_ready;
            hold = ep_out_valid && !ep_out_ready;
            held = ep_out_data;
            exp_done = (idx == n_out) && (rdn == n_rd);
            if (samp > 4000) begin
                chk(1'b0, dtag, "transaction timeout", 32'(samp), 32'd0);
                break;
            end
            @(negedge clk);
        end
        chk(idx == n_out, (kind == 2) ? "R6" : ctag, "output word count",
            32'(idx), 32'(n_out));
        chk(rdn == n_rd, "R7", "read word count", 32'(rdn), 32'(n_rd));
        if (n_out > 0)
            chk(busy_ok, "R10", "ready low while busy", 32'(busy_ok), 32'd1);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single pulse", 32'(done), 32'd0);
    endtask

    // Watchdog: ends a hung run as a failure
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fb;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0;
        req_data = '0; req_len = '0; wr_data = '0; wr_valid = 1'b0;
        rd_ready = 1'b0; ep_out_ready = 1'b0; ep_in_data = '0; ep_in_valid = 1'b0;
        repeat (3) @(negedge clk);
        ep_out_ready = 1'b1; wr_valid = 1'b1; rd_ready = 1'b1; ep_in_valid = 1'b1;
        #1;
        // R1: quiet outputs during reset
        chk(!ep_out_valid && !done, "R1", "outputs in reset",
            {30'd0, ep_out_valid, done}, 32'd0);
        chk(!wr_ready && !rd_valid && !ep_in_ready && req_ready, "R1", "stream in reset",
            {28'd0, wr_ready, rd_valid, ep_in_ready, req_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        run_txn(0, 32'h1000_0040, 32'hDEAD_BEEF, 0, 100, fb);
        run_txn(0, 32'h2000_0000, 32'h0123_4567, 0, 40, fb);
        run_txn(2, 32'h3000_0100, 32'h0, 4, 100, fb);
        chk(fb == 3, "R11", "first write beat cycle", 32'(fb), 32'd3);
        run_txn(1, 32'h4000_0200, 32'h0, 4, 100, fb);
        chk(fb == 3, "R11", "first read beat cycle", 32'(fb), 32'd3);
        run_txn(1, 32'h5000_0000, 32'h0, 0, 100, fb);
        run_txn(2, 32'h5000_0004, 32'h0, 0, 50, fb);
        run_txn(3, 32'h6000_0000, 32'h0, 5, 100, fb);
        run_txn(2, 32'h7000_0000, 32'h0, 1, 35, fb);
        run_txn(1, 32'h7000_0010, 32'h0, 1, 35, fb);
        run_txn(1, 32'h8000_0000, 32'h0, (1 << 21) + 3 - (1 << 21), 60, fb);

        // Seeded random mix
        for (int t = 0; t < 80; t++) begin
            int k, l, p;
            k = ($urandom % 10 == 0) ? 3 : int'($urandom % 3);
            l = int'($urandom % 13);
            p = 30 + int'($urandom % 71);
            run_txn(k, $urandom, $urandom, l, p, fb);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule